// File: doc/BRIEF.md
# Cascadable Quadrature Phase Counter

This block tracks motion from two pairs of phase inputs, where each pair carries two square waves a quarter period apart. Each pair feeds its own 16-bit counter. The counter counts up or down depending on which input of the pair leads. Every input first passes through a synchroniser, and each transition is then decoded in x4 fashion: every legal edge on either input moves the count by exactly one.

A single mode input, `link_en`, sets how the two counters are used. With `link_en` low, the two counters run independently. With `link_en` high, they form one 32-bit counter driven by the channel 0 pair. In that mode channel 0 holds the lower half and channel 1 holds the upper half. Wrap events come out as one-cycle pulses. A transition in which both inputs of a pair change in the same cycle cannot be decoded, so it is dropped and recorded in a sticky per-pair error flag. Software can load either counter through a write strobe, and a load takes precedence over a count arriving in the same cycle.

Top module: `qpc_top`

## Requirements
- R1: The Gray index of a pair is 0 for {a,b}=00, 1 for 01, 2 for 11 and 3 for 10. A step that raises the index by one (modulo 4) increments the count by one.
- R2: A step that lowers the Gray index by one (modulo 4) decrements the count by one.
- R3: A step that changes both inputs of a pair at once leaves every count unchanged. It sets that pair's error flag (`err[0]` or `err[1]`), which stays set until reset. The flag follows its pair in either mode.
- R4: With `link_en` low, channel 0 and channel 1 each count only from their own pair and wrap at 16 bits.
- R5: In independent mode, an increment from 16'hFFFF gives 0 and raises that channel's `ovf` bit for exactly one clock cycle.
- R6: In independent mode, a decrement from 0 gives 16'hFFFF and raises that channel's `unf` bit for exactly one clock cycle.
- R7: With `link_en` high, {`ch1_count`,`ch0_count`} is one 32-bit counter stepped only by the channel 0 pair. A carry passes from the lower half into the upper half, and steps on the channel 1 pair do not change the count.
- R8: With `link_en` high, `ovf[1]`/`unf[1]` pulse for one cycle only when the 32-bit value wraps. `ovf[0]` and `unf[0]` stay low, including when the lower half wraps.
- R9: When `wr_en` is high, the counter or half picked by `wr_sel` (0 = channel 0 / lower half, 1 = channel 1 / upper half) loads `wr_data` at the next clock edge. A step due in that same cycle is discarded.
- R10: After reset, both counts are 0 and all `ovf`, `unf` and `err` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | 1 joins both channels into one 32-bit counter |
| ph0_a | input | 1 | Channel 0 phase input A (asynchronous) |
| ph0_b | input | 1 | Channel 0 phase input B (asynchronous) |
| ph1_a | input | 1 | Channel 1 phase input A (asynchronous) |
| ph1_b | input | 1 | Channel 1 phase input B (asynchronous) |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 1 | Load target: 0 channel 0 / lower half, 1 channel 1 / upper half |
| wr_data | input | 16 | Load value |
| ch0_count | output | 16 | Channel 0 count / lower half |
| ch1_count | output | 16 | Channel 1 count / upper half |
| ovf | output | 2 | Per-channel overflow pulse |
| unf | output | 2 | Per-channel underflow pulse |
| err | output | 2 | Per-pair sticky illegal-transition flag |

## Verification
The bench targets the following wrap and boundary cases:
- 16-bit wraps in both directions. A design that pulses the wrong channel or holds the pulse too long is caught, because the bench counts pulse cycles at the output.
- The lower-half wrap in linked mode. A missing carry leaves the upper half stale, and a pulse reported on channel 0 there is counted as an error.
- Double-edge steps. A decoder that treats these as a count moves the value, and a non-sticky flag drops back to 0.
- A load timed to land in the same cycle as a pending step. A design that lets the step win shows the loaded value off by one.

Long random walks in both modes check direction decoding and channel isolation.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // Position of a pair on the quadrature cycle 00 -> 01 -> 11 -> 10.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pins,
    output logic [1:0] cur_o,
    output logic [1:0] prev_o
);
    typedef struct packed {
        logic [STAGES-1:0][1:0] chain;
        logic [1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pins;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic [1:0] cur_ab,
    input  logic [1:0] prev_ab,
    output step_e      step_o
);
    logic [1:0] delta;

    always_comb begin
        delta = gray_pos(cur_ab) - gray_pos(prev_ab);
        unique case (delta)
            2'd1:    step_o = STEP_UP;
            2'd3:    step_o = STEP_DOWN;
            2'd2:    step_o = STEP_BAD;
            default: step_o = STEP_NONE;
        endcase
    end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_en,
    input  logic          ph0_a,
    input  logic          ph0_b,
    input  logic          ph1_a,
    input  logic          ph1_b,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] ch0_count,
    output logic [CW-1:0] ch1_count,
    output logic [1:0]    ovf,
    output logic [1:0]    unf,
    output logic [1:0]    err
);
    localparam int NCH = 2;
    localparam int WW  = 2 * CW;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0]         ovf;
        logic [NCH-1:0]         unf;
        logic [NCH-1:0]         err;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0][1:0] pins;
    logic [NCH-1:0][1:0] cur_ab;
    logic [NCH-1:0][1:0] prev_ab;
    step_e               step [NCH];

    assign pins[0] = {ph0_a, ph0_b};
    assign pins[1] = {ph1_a, ph1_b};

    for (genvar g = 0; g < NCH; g++) begin : g_front
        qpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins   (pins[g]),
            .cur_o  (cur_ab[g]),
            .prev_o (prev_ab[g])
        );
        qpc_decode u_dec (
            .cur_ab  (cur_ab[g]),
            .prev_ab (prev_ab[g]),
            .step_o  (step[g])
        );
    end

    logic [WW-1:0] wide_q;
    logic [WW-1:0] wide_d;

    assign wide_q = {st_q.cnt[1], st_q.cnt[0]};

    always_comb begin
        st_d     = st_q;
        st_d.ovf = '0;
        st_d.unf = '0;
        wide_d   = wide_q;
        for (int i = 0; i < NCH; i++) begin
            if (step[i] == STEP_BAD) st_d.err[i] = 1'b1;
        end
        if (!link_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_en && (wr_sel == 1'(i))) begin
                    st_d.cnt[i] = wr_data;
                end else if (step[i] == STEP_UP) begin
                    st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                    st_d.ovf[i] = &st_q.cnt[i];
                end else if (step[i] == STEP_DOWN) begin
                    st_d.cnt[i] = st_q.cnt[i] - 1'b1;
                    st_d.unf[i] = ~|st_q.cnt[i];
                end
            end
        end else begin
            if (wr_en) begin
                st_d.cnt[wr_sel] = wr_data;
            end else if (step[0] == STEP_UP) begin
                wide_d      = wide_q + 1'b1;
                st_d.ovf[1] = &wide_q;
            end else if (step[0] == STEP_DOWN) begin
                wide_d      = wide_q - 1'b1;
                st_d.unf[1] = ~|wide_q;
            end
            if (!wr_en) begin
                st_d.cnt[0] = wide_d[CW-1:0];
                st_d.cnt[1] = wide_d[WW-1:CW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch0_count = st_q.cnt[0];
    assign ch1_count = st_q.cnt[1];
    assign ovf       = st_q.ovf;
    assign unf       = st_q.unf;
    assign err       = st_q.err;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_WRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.ovf[g] && st_q.unf[g])); // R5
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(st_q.err[g]) |-> st_q.err[g]); // R3
        AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && (wr_sel == 1'(g)) && !link_en) |-> st_q.cnt[g] == $past(wr_data)); // R9
        AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(step[g] == STEP_BAD && !link_en && !wr_en) |-> $stable(st_q.cnt[g])); // R3
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!link_en && !wr_en) |->
                (st_q.cnt[g] == $past(st_q.cnt[g]) ||
                 st_q.cnt[g] == $past(st_q.cnt[g]) + 1'b1 ||
                 st_q.cnt[g] == $past(st_q.cnt[g]) - 1'b1)); // R4
    end

    AST_LINK_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_en) |-> !st_q.ovf[0] && !st_q.unf[0]); // R8
    AST_LINK_CH1_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_en && !wr_en && step[0] == STEP_NONE) |-> $stable(wide_q)); // R7
endmodule

// File: tb/qpc_top_tb.sv
`timescale 1ns/1ps
module qpc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en = 1'b0;
    logic        ph0_a = 1'b0, ph0_b = 1'b0, ph1_a = 1'b0, ph1_b = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ch0_count, ch1_count;
    logic [1:0]  ovf, unf, err;

    always #4 clk = ~clk;

    qpc_top u_dut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .ph0_a(ph0_a), .ph0_b(ph0_b), .ph1_a(ph1_a), .ph1_b(ph1_b),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ch0_count(ch0_count), .ch1_count(ch1_count),
        .ovf(ovf), .unf(unf), .err(err)
    );

    int checks = 0;
    int errors = 0;
    logic [1:0]  pos [2];
    logic [15:0] m_cnt [2];
    int          m_ovf [2];
    int          m_unf [2];
    logic [1:0]  m_err;
    int          seen_ovf [2];
    int          seen_unf [2];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (ovf[i]) seen_ovf[i]++;
                if (unf[i]) seen_unf[i]++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ab_of(input logic [1:0] p);
        return {p[1], p[1] ^ p[0]};
    endfunction

    task automatic drive_pins();
        {ph0_a, ph0_b} = ab_of(pos[0]);
        {ph1_a, ph1_b} = ab_of(pos[1]);
    endtask

    // kind: 0 up, 1 down, 2 double-edge
    task automatic model_step(input int ch, input int kind);
        logic [31:0] w;
        if (kind == 2) begin
            m_err[ch] = 1'b1;
            return;
        end
        if (!link_en) begin
            if (kind == 0) begin
                if (m_cnt[ch] == 16'hFFFF) m_ovf[ch]++;
                m_cnt[ch] = m_cnt[ch] + 1'b1;
            end else begin
                if (m_cnt[ch] == 16'h0000) m_unf[ch]++;
                m_cnt[ch] = m_cnt[ch] - 1'b1;
            end
        end else if (ch == 0) begin
            w = {m_cnt[1], m_cnt[0]};
            if (kind == 0) begin
                if (w == 32'hFFFF_FFFF) m_ovf[1]++;
                w = w + 1;
            end else begin
                if (w == 32'h0) m_unf[1]++;
                w = w - 1;
            end
            {m_cnt[1], m_cnt[0]} = w;
        end
    endtask

    task automatic step(input int ch, input int kind);
        @(negedge clk);
        pos[ch] = pos[ch] + ((kind == 0) ? 2'd1 : (kind == 1) ? 2'd3 : 2'd2);
        drive_pins();
        model_step(ch, kind);
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        m_cnt[sel] = val;
    endtask

    task automatic check_state(input string req);
        check({req, " count0"}, {16'h0, ch0_count}, {16'h0, m_cnt[0]});
        check({req, " count1"}, {16'h0, ch1_count}, {16'h0, m_cnt[1]});
    endtask

    task automatic check_events(input string req);
        check({req, " ovf0"}, seen_ovf[0], m_ovf[0]);
        check({req, " ovf1"}, seen_ovf[1], m_ovf[1]);
        check({req, " unf0"}, seen_unf[0], m_unf[0]);
        check({req, " unf1"}, seen_unf[1], m_unf[1]);
        check({req, " err"}, {30'h0, err}, {30'h0, m_err});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        for (int i = 0; i < 2; i++) begin
            pos[i] = 2'd0; m_cnt[i] = '0; m_ovf[i] = 0; m_unf[i] = 0;
            seen_ovf[i] = 0; seen_unf[i] = 0;
        end
        m_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check_state("R10");
        check("R10 flags", {26'h0, ovf, unf, err}, 32'h0);

        // R1 / R2 / R4 directed
        for (int i = 0; i < 5; i++) step(0, 0);
        check_state("R1");
        step(0, 1); step(0, 1);
        check_state("R2");
        step(1, 1);
        check_state("R4 R6");
        check_events("R6");
        step(1, 0);
        check_state("R5");
        check_events("R5");

        // R3: double-edge step
        step(0, 2);
        check_state("R3");
        check_events("R3");
        step(0, 0);
        check_events("R3 sticky");

        // R9 + R5 wrap after load
        load(1'b0, 16'hFFFE);
        step(0, 0); step(0, 0);
        check_state("R9 R5");
        check_events("R5 wrap");

        // R9: load lands in the cycle the step would apply
        @(negedge clk);
        pos[0] = pos[0] + 2'd1;
        drive_pins();
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        m_cnt[0] = 16'h1234;
        repeat (3) @(negedge clk);
        check_state("R9 priority");

        // random independent walk (R1 R2 R3 R4)
        for (int n = 0; n < 400; n++) begin
            int ch, kind, sel;
            ch  = int'($urandom_range(0, 1));
            sel = int'($urandom_range(0, 15));
            kind = (sel == 0) ? 2 : (sel < 8) ? 0 : 1;
            if (n % 97 == 5) load(ch[0], 16'hFFFF - 16'(n % 3));
            step(ch, kind);
            check_state("R4 random");
        end
        check_events("R4 random");

        // cascaded mode
        @(negedge clk);
        link_en = 1'b1;
        load(1'b0, 16'hFFFF);
        load(1'b1, 16'h0000);
        step(0, 0);
        check_state("R7 carry");
        check_events("R8 low wrap");
        step(1, 0); step(1, 1); step(1, 1);
        check_state("R7 ch1 ignored");
        load(1'b0, 16'hFFFF);
        load(1'b1, 16'hFFFF);
        step(0, 0);
        check_state("R8 top wrap");
        check_events("R8 ovf");
        step(0, 1);
        check_state("R8 under");
        check_events("R8 unf");

        for (int n = 0; n < 200; n++) begin
            int ch, sel;
            ch  = int'($urandom_range(0, 3) == 0);
            sel = int'($urandom_range(0, 1));
            if (n % 50 == 7) load(1'b0, 16'hFFFE);
            step(ch, sel);
            check_state("R7 random");
        end
        check_events("R8 random");
        finish_run();
    end
endmodule